// File: doc/BRIEF.md
# Dual-Mode Kick Watchdog

This block watches a single kick line from a processor. It reports a fault when that line stays at one level for longer than a set number of clock ticks. A rising edge and a falling edge each restart the count, so software can keep the block quiet by toggling any free output pin. The kick line is asynchronous and passes through a two-flop synchroniser before the edge detector. The timeout lengths are parameters given in clock ticks, which lets a simulation use short windows.

A build-time parameter picks one of two variants:

- **Reset variant.** A timeout raises a one-cycle reset request for an external reset generator. The counter stays clear while that generator reports that reset is active. After power-up, and again after each reset release, the first kick gets a long startup window.
- **Flag variant.** A timeout pulls a separate active-low watchdog flag. That flag also follows the rail power-good inputs, the manual reset line and a margin override.

In both variants, counting starts only after a holdoff period that follows power-up or manual reset release. A strap input switches the watchdog off entirely.

Top module: `kick_watchdog`

## Requirements
- R1: Every rising edge and every falling edge of `kickIn`, once synchronised, restarts the timer. A kick that toggles every 0.6 timeout periods never produces a fault.
- R2: In the reset variant, a timeout makes `rstReq` high for exactly one clock cycle. While `rstActive` is high the timer stays clear and no request is made.
- R3: In the reset variant, after power-up and after each fall of `rstActive`, the time until the first kick is bounded by STARTUP_TICKS instead of TIMEOUT_TICKS. After that first edge, TIMEOUT_TICKS applies.
- R4: In the flag variant there is no startup window. Without kicks, the first fault comes TIMEOUT_TICKS after the holdoff ends.
- R5: In the flag variant, `wdFlagN` is low in the same cycle in which any bit of `railGood` is low. It returns high in the same cycle in which all rails are good again, with no delay.
- R6: In the flag variant, with all rails good, a timeout drives `wdFlagN` low. The flag stays low until the next synchronised kick edge or until `manRstN` is low.
- R7: The timer does not count while `manRstN` is low. It also does not count for HOLDOFF_TICKS cycles after power-up or after `manRstN` rises. The first timeout after a release therefore comes about HOLDOFF_TICKS + limit cycles later.
- R8: In the flag variant, `marginN` low forces `wdFlagN` high. This holds whatever the rail state or fault state.
- R9: While `wdDisable` is high, no timeout is reported on either output, whatever the kick line does.
- R10: The output that a variant does not use stays inactive: `wdFlagN` stays high in the reset variant, and `rstReq` stays low in the flag variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-up reset, active low |
| kickIn | input | 1 | Asynchronous kick line from the processor |
| wdDisable | input | 1 | Strap that switches the watchdog off when high |
| railGood | input | NUM_RAILS | Power-good flag of each monitored rail, high = good |
| manRstN | input | 1 | Manual reset level, active low |
| rstActive | input | 1 | High while the system reset is asserted |
| marginN | input | 1 | Margin override, low forces the flag high |
| rstReq | output | 1 | One-cycle reset request (reset variant) |
| wdFlagN | output | 1 | Watchdog flag, active low (flag variant) |

## Verification
Several kick patterns are applied:

- **No kick at all.** This separates the startup window from the normal timeout, and shows the holdoff delay after power-up or a manual reset.
- **A single edge followed by silence.** This shows that the first edge ends the startup window.
- **A toggle every 0.6 timeouts.** This tells apart a timer that restarts on both edges from one that restarts only on rising edges, because the rising-only version would see a gap of 1.2 timeouts.

On the flag variant, rail drops, the margin override and the manual reset are each applied while a fault is latched and while none is latched. This tells apart the immediate combinational gating from the cleared latch underneath it.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrTimer;
    logic countEn;
    logic useStartup;
    logic loadHoldoff;
  } wdStrobe_t;

  // Status from datapath back to control
  typedef struct packed {
    logic kickEdge;
    logic expired;
    logic holdoffDone;
  } wdStatus_t;

endpackage

// File: rtl/kick_sync.sv
module kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic kickIn,
  output logic kickEdge
);
  localparam int SH_W = STAGES + 1;

  // shQ[STAGES-1] is the synchronised level, shQ[STAGES] its previous value
  logic [SH_W-1:0] shQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shQ <= '0;
    else       shQ <= {shQ[SH_W-2:0], kickIn};
  end

  assign kickEdge = shQ[STAGES] ^ shQ[STAGES-1];
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 20,
  parameter int STARTUP_TICKS = 100,
  parameter int HOLDOFF_TICKS = 10,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       kickIn,
  input  wdStrobe_t  strobe,
  output wdStatus_t  status
);
  localparam int MAX_TICKS = (STARTUP_TICKS > TIMEOUT_TICKS) ? STARTUP_TICKS : TIMEOUT_TICKS;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);
  localparam int HOLD_W    = $clog2(HOLDOFF_TICKS + 2);
  localparam logic [CNT_W-1:0]  T_LAST = CNT_W'(TIMEOUT_TICKS - 1);
  localparam logic [CNT_W-1:0]  S_LAST = CNT_W'(STARTUP_TICKS - 1);
  localparam logic [HOLD_W-1:0] H_LOAD = HOLD_W'(HOLDOFF_TICKS);

  logic              kickEdge;
  logic [CNT_W-1:0]  tmrQ;
  logic [HOLD_W-1:0] holdQ;

  kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .kickIn   (kickIn),
    .kickEdge (kickEdge)
  );

  // Level timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               tmrQ <= '0;
    else if (strobe.clrTimer) tmrQ <= '0;
    else if (strobe.countEn)  tmrQ <= tmrQ + 1'b1;
  end

  // Holdoff after power-up or manual reset release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  holdQ <= H_LOAD;
    else if (strobe.loadHoldoff) holdQ <= H_LOAD;
    else if (holdQ != '0)        holdQ <= holdQ - 1'b1;
  end

  assign status.kickEdge    = kickEdge;
  assign status.expired     = strobe.useStartup ? (tmrQ >= S_LAST) : (tmrQ >= T_LAST);
  assign status.holdoffDone = (holdQ == '0);

  AST_EDGE_CLEARS_TIMER: assert property (@(posedge clk) disable iff (!rstN)
    kickEdge |=> (tmrQ == '0)); // R1

endmodule

// File: rtl/wdog_control.sv
module wdog_control
  import wdog_pkg::*;
#(
  parameter bit RESET_MODE = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  wdStatus_t status,
  input  logic      wdDisable,
  input  logic      allGood,
  input  logic      manRstN,
  input  logic      rstActive,
  output wdStrobe_t strobe,
  output logic      rstReqQ,
  output logic      faultQ
);
  logic countEn;
  logic timeoutEvt;
  logic armedQ;

  assign countEn    = !wdDisable && !rstActive && manRstN && allGood
                      && status.holdoffDone && !faultQ;
  assign timeoutEvt = countEn && status.expired && !status.kickEdge;

  assign strobe.countEn     = countEn;
  assign strobe.clrTimer    = !countEn || status.kickEdge || timeoutEvt;
  assign strobe.loadHoldoff = !manRstN;
  assign strobe.useStartup  = armedQ;

  generate
    if (RESET_MODE) begin : g_reset
      // Startup window armed at power-up and during each reset
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                armedQ <= 1'b1;
        else if (rstActive)       armedQ <= 1'b1;
        else if (status.kickEdge) armedQ <= 1'b0;
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rstReqQ <= 1'b0;
        else       rstReqQ <= timeoutEvt;
      end

      assign faultQ = 1'b0;

      AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
        rstReqQ |=> !rstReqQ); // R2
      AST_NO_REQ_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
        rstActive |=> !rstReqQ); // R2
    end else begin : g_flag
      assign armedQ  = 1'b0;
      assign rstReqQ = 1'b0;

      // Fault latch for the watchdog flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                   faultQ <= 1'b0;
        else if (wdDisable || !allGood || !manRstN ||
                 status.kickEdge)                    faultQ <= 1'b0;
        else if (timeoutEvt)                         faultQ <= 1'b1;
      end

      AST_MR_CLEARS_FAULT: assert property (@(posedge clk) disable iff (!rstN)
        !manRstN |=> !faultQ); // R6
    end
  endgenerate

  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    wdDisable |=> (!rstReqQ && !faultQ)); // R9
  AST_HOLDOFF_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    !status.holdoffDone |=> (!rstReqQ && (!faultQ || $past(faultQ)))); // R7

endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog
  import wdog_pkg::*;
#(
  parameter bit RESET_MODE    = 1'b1,
  parameter int NUM_RAILS     = 3,
  parameter int TIMEOUT_TICKS = 20,
  parameter int STARTUP_TICKS = 100,
  parameter int HOLDOFF_TICKS = 10,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 kickIn,
  input  logic                 wdDisable,
  input  logic [NUM_RAILS-1:0] railGood,
  input  logic                 manRstN,
  input  logic                 rstActive,
  input  logic                 marginN,
  output logic                 rstReq,
  output logic                 wdFlagN
);
  wdStrobe_t strobe;
  wdStatus_t status;
  logic      allGood;
  logic      faultQ;

  assign allGood = &railGood;

  wdog_datapath #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS),
    .STARTUP_TICKS (STARTUP_TICKS),
    .HOLDOFF_TICKS (HOLDOFF_TICKS),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .kickIn (kickIn),
    .strobe (strobe),
    .status (status)
  );

  wdog_control #(.RESET_MODE(RESET_MODE)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .status    (status),
    .wdDisable (wdDisable),
    .allGood   (allGood),
    .manRstN   (manRstN),
    .rstActive (rstActive),
    .strobe    (strobe),
    .rstReqQ   (rstReq),
    .faultQ    (faultQ)
  );

  generate
    if (RESET_MODE) begin : g_flagOff
      assign wdFlagN = 1'b1;
    end else begin : g_flagOn
      assign wdFlagN = !marginN || (allGood && !faultQ);
    end
  endgenerate

endmodule

// File: tb/sim_kick_watchdog.sv
module sim_kick_watchdog;
  localparam int T = 20;
  localparam int S = 100;
  localparam int H = 10;
  localparam int NR = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  // Reset-variant stimulus
  logic aKick = 0, aDis = 0, aMr = 1, aAct = 0, aMargin = 1;
  logic [NR-1:0] aRails = '1;
  logic aReq, aFlag;
  // Flag-variant stimulus
  logic bKick = 0, bDis = 0, bMr = 1, bAct = 0, bMargin = 1;
  logic [NR-1:0] bRails = '1;
  logic bReq, bFlag;

  int checks = 0;
  int fails = 0;
  int aFlagLow = 0;
  int bReqHigh = 0;
  bit running = 0;
  bit finished = 0;

  kick_watchdog #(.RESET_MODE(1'b1), .NUM_RAILS(NR), .TIMEOUT_TICKS(T),
                  .STARTUP_TICKS(S), .HOLDOFF_TICKS(H)) u0 (
    .clk(clk), .rstN(rstN), .kickIn(aKick), .wdDisable(aDis), .railGood(aRails),
    .manRstN(aMr), .rstActive(aAct), .marginN(aMargin), .rstReq(aReq), .wdFlagN(aFlag));

  kick_watchdog #(.RESET_MODE(1'b0), .NUM_RAILS(NR), .TIMEOUT_TICKS(T),
                  .STARTUP_TICKS(S), .HOLDOFF_TICKS(H)) u1 (
    .clk(clk), .rstN(rstN), .kickIn(bKick), .wdDisable(bDis), .railGood(bRails),
    .manRstN(bMr), .rstActive(bAct), .marginN(bMargin), .rstReq(bReq), .wdFlagN(bFlag));

  always @(negedge clk) begin
    if (running) begin
      if (!aFlag) aFlagLow++;
      if (bReq) bReqHigh++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // Cycles until rstReq of u0 is seen, up to maxN
  task automatic waitReqA(input int maxN, output int n);
    n = 0;
    while (n < maxN) begin
      @(negedge clk); n++;
      if (aReq) break;
    end
  endtask

  // Cycles until wdFlagN of u1 falls, up to maxN
  task automatic waitFlagLowB(input int maxN, output int n);
    n = 0;
    while (n < maxN) begin
      @(negedge clk); n++;
      if (!bFlag) break;
    end
  endtask

  task automatic countReqA(input int cyc, output int p);
    p = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (aReq) p++;
    end
  endtask

  task automatic pulseActA();
    @(negedge clk); aAct = 1;
    repeat (4) @(negedge clk);
    aAct = 0;
  endtask

  task automatic tReset();
    check(aReq == 0, "R2", "rstReq after reset", aReq, 0);
    check(bFlag == 1, "R5", "flag after reset", bFlag, 1);
    check(bReq == 0, "R10", "flag variant rstReq after reset", bReq, 0);
  endtask

  task automatic tPowerUpStartup();
    int n;
    waitReqA(H + S + 10, n);
    check(n >= H + S - 3 && n <= H + S + 3, "R3", "power-up startup cycles (R7 holdoff)", n, H + S);
    @(negedge clk);
    check(aReq == 0, "R2", "request width one cycle", aReq, 0);
  endtask

  task automatic tHoldInReset();
    int p;
    int n;
    @(negedge clk); aAct = 1;
    countReqA(3 * S, p);
    check(p == 0, "R2", "requests while reset active", p, 0);
    aAct = 0;
    waitReqA(S + 10, n);
    check(n >= S - 3 && n <= S + 3, "R3", "startup after reset release", n, S);
  endtask

  task automatic tSingleKick();
    int n;
    pulseActA();
    repeat (3) @(negedge clk);
    aKick = ~aKick;
    waitReqA(S + 10, n);
    check(n >= T - 1 && n <= T + 6, "R3", "normal timeout after first kick", n, T + 3);
  endtask

  task automatic tBothEdges();
    int p;
    int n;
    pulseActA();
    p = 0;
    for (int k = 0; k < 20; k++) begin
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        if (aReq) p++;
      end
      aKick = ~aKick;
    end
    check(p == 0, "R1", "requests with toggle every 12 cycles", p, 0);
    waitReqA(T + 10, n);
    check(n >= T - 1 && n <= T + 6, "R1", "timeout after toggling stops", n, T + 3);
  endtask

  task automatic tDisableA();
    int p;
    pulseActA();
    aDis = 1;
    countReqA(2 * S, p);
    check(p == 0, "R9", "reset variant requests while disabled", p, 0);
    aDis = 0;
  endtask

  task automatic tFlagHoldoff();
    int n;
    check(bFlag == 0, "R6", "flag variant faulted after long silence", bFlag, 0);
    @(negedge clk); bMr = 0;
    @(negedge clk); @(negedge clk);
    check(bFlag == 1, "R6", "manual reset clears flag", bFlag, 1);
    bMr = 1;
    waitFlagLowB(H + S + 10, n);
    check(n >= H + T - 2 && n <= H + T + 4, "R4", "first fault after holdoff (R7)", n, H + T + 1);
  endtask

  task automatic tKickRelease();
    int n;
    @(negedge clk); bKick = ~bKick;
    repeat (5) @(negedge clk);
    check(bFlag == 1, "R6", "kick edge releases flag", bFlag, 1);
    waitFlagLowB(T + 20, n);
    check(n >= T - 4 && n <= T + 4, "R6", "fault again after timeout", n, T);
  endtask

  task automatic tRails();
    @(negedge clk); bKick = ~bKick;
    repeat (5) @(negedge clk);
    bRails[1] = 0;
    #1 check(bFlag == 0, "R5", "flag low same cycle as rail drop", bFlag, 0);
    repeat (3) @(negedge clk);
    bMargin = 0;
    #1 check(bFlag == 1, "R8", "margin overrides bad rail", bFlag, 1);
    @(negedge clk); bMargin = 1;
    @(negedge clk); bRails[1] = 1;
    #1 check(bFlag == 1, "R5", "flag high same cycle as rails good", bFlag, 1);
  endtask

  task automatic tMarginFault();
    int n;
    waitFlagLowB(T + 20, n);
    check(bFlag == 0, "R6", "fault latched before margin test", bFlag, 0);
    @(negedge clk); bMargin = 0;
    #1 check(bFlag == 1, "R8", "margin overrides fault", bFlag, 1);
    @(negedge clk); bMargin = 1;
    #1 check(bFlag == 0, "R8", "fault still latched after margin", bFlag, 0);
  endtask

  task automatic tDisableB();
    int low;
    @(negedge clk); bDis = 1;
    @(negedge clk); @(negedge clk);
    low = 0;
    for (int i = 0; i < 3 * (H + T); i++) begin
      @(negedge clk);
      if (!bFlag) low++;
    end
    check(low == 0, "R9", "flag low cycles while disabled", low, 0);
    bDis = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual 1 expected 0");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    running = 1;
    #1 tReset();
    tPowerUpStartup();
    tHoldInReset();
    tSingleKick();
    tBothEdges();
    tDisableA();
    tFlagHoldoff();
    tKickRelease();
    tRails();
    tMarginFault();
    tDisableB();
    check(aFlagLow == 0, "R10", "reset variant flag low cycles", aFlagLow, 0);
    check(bReqHigh == 0, "R10", "flag variant request cycles", bReqHigh, 0);
    finishRun();
  end
endmodule